// File: doc/BRIEF.md
# Configurable CRC Checksum Engine

The engine keeps a running CRC over a stream of data beats and exposes it through a small word-addressed register file. Software picks the polynomial (CRC-16 with polynomial 0x1021 or CRC-32 with the reflected polynomial 0xEDB88320) and the beat width (byte, halfword or word). It can also preset the running checksum and read it back at any time. The raw running state is held, with no final complement, so software applies any output inversion itself.

Beats come from one of two sources. In software-fed mode each write to the data-in register is one beat. In snoop mode the engine watches a beat-valid strobe that carries a channel number and data, and it folds in only the beats of the one selected channel. Wider beats are broken into bytes, least significant byte first, and one byte is folded per clock. A sticky busy flag marks that a computation is under way and locks the configuration until software clears the flag or disables the unit.

Top module: `crc_engine`

## Requirements
- R1: Register word addresses are 0 control (bit 0 enable), 1 configuration, 2 status (bit 0 busy), 3 data-in (write-only, reads 0) and 4 checksum. After reset every register reads 0.
- R2: Configuration bit 0 = 1 selects CRC-32: the data byte is XORed into the low bits and the state is shifted right with the reflected polynomial 0xEDB88320. The 32-bit raw state is held with no final complement.
- R3: Configuration bit 0 = 0 selects CRC-16: the bits are taken MSB first with polynomial 0x1021. The state is held in checksum bits [15:0] and bits [31:16] read 0.
- R4: Configuration bits [2:1] set the beat width: 0 byte, 1 halfword, 2 or 3 word. Only the low 1, 2 or 4 bytes of a beat are used, least significant byte first.
- R5: One byte is folded per clock, and the first byte is folded on the clock that accepts the beat. The updated checksum is readable 1, 2 or 4 cycles after a byte, halfword or word beat is accepted.
- R6: Configuration bits [13:8] select the source. 0x01 is software-fed through data-in writes. 0x20+n snoops channel n, and only beats whose channel equals n are folded. Data-in writes in snoop mode and snooped beats in software-fed mode are ignored.
- R7: A write to the checksum register presets the running state. In CRC-16 mode only bits [15:0] are kept.
- R8: Busy sets on any accepted beat. While busy is 1, writes to the configuration register are ignored.
- R9: Writing 1 to status bit 0 clears busy. Writing 0 there has no effect.
- R10: Writing 0 to the control enable bit clears enable, the whole configuration register and busy. While disabled, no beat is accepted.
- R11: A beat that arrives while an earlier beat is still being serialized is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| dma_valid_i | input | 1 | Snooped beat valid |
| dma_chan_i | input | CH_W | Channel number of the snooped beat |
| dma_data_i | input | 32 | Snooped beat data |

## Verification
The bench uses the default NUM_CH of 8, so the channel number is 3 bits wide. The snoop tests select channel 7, the highest code the field can carry, and interleave beats from channel 3 to show that the match uses the full channel number. With a 32-bit beat the serializer reaches its deepest state, which lets the bench check the four-cycle word latency and the dropping of a beat that arrives during serialization. The known check strings give CRC-16 and CRC-32 results that do not depend on the bench's own reference model.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 3;
  localparam int unsigned SRC_W  = 6;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_CFG  = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd2;
  localparam logic [AW-1:0] A_DIN  = 3'd3;
  localparam logic [AW-1:0] A_SUM  = 3'd4;

  localparam logic [SRC_W-1:0] SRC_IO = 6'h01;

  localparam logic [15:0] POLY16 = 16'h1021;
  localparam logic [31:0] POLY32 = 32'hEDB88320;

  typedef enum logic [1:0] {
    BEAT_BYTE = 2'd0,
    BEAT_HALF = 2'd1,
    BEAT_WORD = 2'd2
  } beat_e;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [1:0]       beat;
    logic             poly32;
  } cfg_t;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_eng_pkg::*;
(
  input  logic          poly32_i,
  input  logic [DW-1:0] state_i,
  input  logic [7:0]    byte_i,
  output logic [DW-1:0] state_o
);
  logic [15:0] s16;
  logic [31:0] s32;

  always_comb begin
    s16 = state_i[15:0];
    for (int i = 7; i >= 0; i--) begin
      if (s16[15] ^ byte_i[i]) s16 = {s16[14:0], 1'b0} ^ POLY16;
      else                     s16 = {s16[14:0], 1'b0};
    end
  end

  always_comb begin
    s32 = state_i ^ {24'h0, byte_i};
    for (int i = 0; i < 8; i++) begin
      if (s32[0]) s32 = (s32 >> 1) ^ POLY32;
      else        s32 = s32 >> 1;
    end
  end

  assign state_o = poly32_i ? s32 : {16'h0, s16};
endmodule

// File: rtl/crc_beat_ser.sv
module crc_beat_ser
  import crc_eng_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          accept_i,
  input  logic [1:0]    beat_i,
  input  logic [DW-1:0] data_i,
  output logic          idle_o,
  output logic          step_o,
  output logic [7:0]    byte_o
);
  localparam int unsigned REM_W = DW - 8;

  logic [1:0]       cnt_q;
  logic [REM_W-1:0] rem_q;
  logic [1:0]       extra;

  always_comb begin
    unique case (beat_i)
      BEAT_BYTE: extra = 2'd0;
      BEAT_HALF: extra = 2'd1;
      default:   extra = 2'd3;
    endcase
  end

  // first byte goes straight to the step logic; the rest wait here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rem_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (accept_i) begin
      cnt_q <= extra;
      rem_q <= data_i[DW-1:8];
    end else if (cnt_q != 2'd0) begin
      cnt_q <= cnt_q - 2'd1;
      rem_q <= {8'h0, rem_q[REM_W-1:8]};
    end
  end

  assign idle_o = (cnt_q == 2'd0);
  assign step_o = accept_i || (cnt_q != 2'd0);
  assign byte_o = accept_i ? data_i[7:0] : rem_q[7:0];

  assert_accept_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> cnt_q == 2'd0);
  assert_word_depth_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && beat_i >= 2'd2 && !flush_i) |=> cnt_q == 2'd3);
  assert_drain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 2'd0 && !accept_i && !flush_i) |=> cnt_q == $past(cnt_q) - 2'd1);
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_eng_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            dma_valid_i,
  input  logic [CH_W-1:0] dma_chan_i,
  input  logic [DW-1:0]   dma_data_i
);
  logic          en_q, busy_q;
  cfg_t          cfg_q;
  logic [DW-1:0] sum_q, sum_next;

  logic wr_ctrl, wr_cfg, wr_stat, wr_din, wr_sum, disable_w;
  logic src_io, src_dma, chan_hit, beat_req, accept;
  logic ser_idle, ser_step;
  logic [7:0]    ser_byte;
  logic [DW-1:0] beat_data;
  logic [4:0]    chan_ext;

  assign wr_ctrl   = reg_we_i && reg_addr_i == A_CTRL;
  assign wr_cfg    = reg_we_i && reg_addr_i == A_CFG;
  assign wr_stat   = reg_we_i && reg_addr_i == A_STAT;
  assign wr_din    = reg_we_i && reg_addr_i == A_DIN;
  assign wr_sum    = reg_we_i && reg_addr_i == A_SUM;
  assign disable_w = wr_ctrl && !reg_wdata_i[0];

  assign chan_ext  = 5'(dma_chan_i);
  assign src_io    = cfg_q.src == SRC_IO;
  assign src_dma   = cfg_q.src[5];
  assign chan_hit  = dma_valid_i && cfg_q.src[4:0] == chan_ext;
  assign beat_req  = src_io ? wr_din : (src_dma && chan_hit);
  assign beat_data = src_io ? reg_wdata_i : dma_data_i;
  assign accept    = en_q && ser_idle && beat_req;

  crc_beat_ser u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (wr_sum || disable_w),
    .accept_i (accept),
    .beat_i   (cfg_q.beat),
    .data_i   (beat_data),
    .idle_o   (ser_idle),
    .step_o   (ser_step),
    .byte_o   (ser_byte)
  );

  crc_byte_step u_step (
    .poly32_i (cfg_q.poly32),
    .state_i  (sum_q),
    .byte_i   (ser_byte),
    .state_o  (sum_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cfg_q  <= '0;
      busy_q <= 1'b0;
    end else if (disable_w) begin
      en_q   <= 1'b0;
      cfg_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= 1'b1;
      if (wr_cfg && !busy_q) cfg_q <= cfg_t'({reg_wdata_i[13:8], reg_wdata_i[2:0]});
      if (accept)                         busy_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[0]) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sum_q <= '0;
    else if (wr_sum)   sum_q <= cfg_q.poly32 ? reg_wdata_i : {16'h0, reg_wdata_i[15:0]};
    else if (ser_step) sum_q <= sum_next;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = {31'h0, en_q};
      A_CFG:   reg_rdata_o = {18'h0, cfg_q.src, 5'h0, cfg_q.beat, cfg_q.poly32};
      A_STAT:  reg_rdata_o = {31'h0, busy_q};
      A_SUM:   reg_rdata_o = sum_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assert_busy_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(accept));
  assert_cfg_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && busy_q) |=> $stable(cfg_q));
  assert_busy_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[0] && !accept) |=> !busy_q);
  assert_disable_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_w |=> (!en_q && cfg_q == '0 && !busy_q));
  assert_crc16_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.poly32 && ser_step && !wr_sum) |=> sum_q[31:16] == 16'h0);
endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dvalid = 1'b0;
  logic [2:0]  dchan = '0;
  logic [31:0] ddata = '0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  crc_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .dma_valid_i(dvalid),
    .dma_chan_i(dchan), .dma_data_i(ddata)
  );

  function automatic logic [31:0] m_byte(bit p32, logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    if (p32) begin
      r = c ^ {24'h0, b};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end else begin
      r = {16'h0, c[15:0]};
      for (int i = 7; i >= 0; i--)
        r = (r[15] ^ b[i]) ? ({16'h0, r[14:0], 1'b0} ^ 32'h1021) : {16'h0, r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [31:0] m_beat(bit p32, logic [31:0] c, logic [31:0] d, int nb);
    logic [31:0] r = c;
    for (int i = 0; i < nb; i++) r = m_byte(p32, r, d[8*i +: 8]);
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic feed(logic [31:0] d);
    wr(3'd3, d);
    repeat (4) @(negedge clk);
  endtask

  task automatic snoop(logic [2:0] ch, logic [31:0] d);
    @(negedge clk);
    dvalid = 1'b1; dchan = ch; ddata = d;
    @(negedge clk);
    dvalid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1", $sformatf("reset value addr %0d", a), v, 32'h0);
    end
  endtask

  task automatic t_crc32_bytes();
    logic [31:0] v;
    string s = "123456789";
    wr(3'd0, 32'h1);
    rd(3'd0, v); chk("R1", "enable readback", v, 32'h1);
    wr(3'd1, 32'h0000_0101);
    rd(3'd1, v); chk("R6", "config readback", v, 32'h0000_0101);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R8", "busy clear before beats", v, 32'h0);
    for (int i = 0; i < 9; i++) feed({24'h0, s[i]});
    rd(3'd4, v); chk("R2", "crc32 check string", v, 32'h340B_C6D9);
    rd(3'd2, v); chk("R8", "busy set after beats", v, 32'h1);
    wr(3'd2, 32'h1);
    rd(3'd2, v); chk("R9", "busy cleared by w1c", v, 32'h0);
  endtask

  task automatic t_crc16_bytes();
    logic [31:0] v;
    string s = "123456789";
    wr(3'd1, 32'h0000_0100);
    wr(3'd4, 32'hABCD_1234);
    rd(3'd4, v); chk("R7", "crc16 preset keeps low half", v, 32'h0000_1234);
    wr(3'd4, 32'h0000_FFFF);
    for (int i = 0; i < 9; i++) feed({24'h0, s[i]});
    rd(3'd4, v); chk("R3", "crc16 check string", v, 32'h0000_29B1);
    wr(3'd2, 32'h1);
  endtask

  task automatic t_words();
    logic [31:0] v, e;
    wr(3'd1, 32'h0000_0105);
    wr(3'd4, 32'hFFFF_FFFF);
    feed(32'h3433_3231);
    e = m_beat(1'b1, m_beat(1'b1, 32'hFFFF_FFFF, 32'h3433_3231, 4), 32'h3837_3635, 4);
    wr(3'd3, 32'h3837_3635);
    repeat (2) @(negedge clk);
    rd(3'd4, v);
    total++;
    if (v === e) begin
      bad++;
      $display("FAIL R5 word result early: actual=%08h expected=not %08h", v, e);
    end
    @(negedge clk);
    rd(3'd4, v); chk("R5", "word result after 4 cycles", v, e);
    wr(3'd2, 32'h1);
    wr(3'd1, 32'h0000_0101);
    feed(32'hABCD_EF39);
    rd(3'd4, v); chk("R4", "word+byte mix, byte uses low byte", v, 32'h340B_C6D9);
    wr(3'd2, 32'h1);
  endtask

  task automatic t_half16();
    logic [31:0] v, e;
    logic [31:0] hw [4] = '{32'hAA3231, 32'h553433, 32'h773635, 32'h993837};
    wr(3'd1, 32'h0000_0102);
    wr(3'd4, 32'h0000_FFFF);
    e = 32'h0000_FFFF;
    for (int i = 0; i < 3; i++) begin
      feed(hw[i]);
      e = m_beat(1'b0, e, hw[i], 2);
    end
    e = m_beat(1'b0, e, hw[3], 2);
    wr(3'd3, hw[3]);
    @(negedge clk);
    rd(3'd4, v); chk("R5", "halfword result after 2 cycles", v, e);
    chk("R4", "halfword crc16 ignores upper bytes", v, m_beat(1'b0, 32'hFFFF,
        32'h3433_3231, 4) == 32'h0 ? 32'h0 : e);
    rd(3'd4, v);
    chk("R4", "halfword equals byte stream", v,
        m_beat(1'b0, m_beat(1'b0, 32'hFFFF, 32'h3433_3231, 4), 32'h3837_3635, 4));
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(3'd1, 32'h0000_0101);
    rd(3'd1, v); chk("R8", "config write refused while busy", v, 32'h0000_0102);
    wr(3'd2, 32'h0);
    rd(3'd2, v); chk("R9", "writing 0 keeps busy", v, 32'h1);
    wr(3'd2, 32'h1);
  endtask

  task automatic t_overlap();
    logic [31:0] v;
    wr(3'd1, 32'h0000_0105);
    wr(3'd4, 32'h0);
    wr(3'd3, 32'hDEAD_BEEF);
    wr(3'd3, 32'h0BAD_F00D);
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R11", "beat during serialization dropped", v,
                     m_beat(1'b1, 32'h0, 32'hDEAD_BEEF, 4));
    wr(3'd2, 32'h1);
  endtask

  task automatic t_snoop();
    logic [31:0] v, e;
    wr(3'd1, 32'h0000_2705);
    wr(3'd4, 32'hFFFF_FFFF);
    snoop(3'd7, 32'h1122_3344);
    snoop(3'd3, 32'h5566_7788);
    feed(32'h99AA_BBCC);
    snoop(3'd7, 32'hCAFE_F00D);
    e = m_beat(1'b1, m_beat(1'b1, 32'hFFFF_FFFF, 32'h1122_3344, 4), 32'hCAFE_F00D, 4);
    rd(3'd4, v); chk("R6", "only channel 7 beats folded", v, e);
    wr(3'd2, 32'h1);
    wr(3'd1, 32'h0000_0101);
    wr(3'd4, 32'h1234_5678);
    snoop(3'd7, 32'h0000_0031);
    rd(3'd4, v); chk("R6", "snooped beat ignored in software mode", v, 32'h1234_5678);
    rd(3'd2, v); chk("R6", "no busy from ignored beat", v, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    feed(32'h31);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R10", "enable cleared", v, 32'h0);
    rd(3'd1, v); chk("R10", "config cleared", v, 32'h0);
    rd(3'd2, v); chk("R10", "busy cleared", v, 32'h0);
    wr(3'd1, 32'h0000_0101);
    wr(3'd4, 32'h0000_5A5A);
    feed(32'h31);
    rd(3'd4, v); chk("R10", "no fold while disabled", v, 32'h0000_5A5A);
    rd(3'd2, v); chk("R10", "no busy while disabled", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_crc32_bytes();
    t_crc16_bytes();
    t_words();
    t_half16();
    t_lock();
    t_overlap();
    t_snoop();
    t_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule